// File: doc/BRIEF.md
# Tag Check Fault Dispatcher

This block decides the response to a failed memory tag comparison. A failure event arrives as a valid/ready transfer. It carries the faulting 64-bit address, the exception level that made the access, a flag that says whether the translation regime splits the address space into two ranges, and the current system control word. The block takes a 2-bit fault-mode field from that control word. Which field it reads depends on whether the access came from the user level. The mode then selects one of four responses: ignore the failure, issue a synchronous abort, set a sticky asynchronous status flag, or pulse a reserved-mode indication.

Synchronous aborts leave the block on a one-entry valid/ready output stage. An abort carries the faulting address and a fixed fault status code. Back-pressure works as follows. While an abort is held and the consumer keeps `abort_ready` low, `fail_ready` stays low and no new failure is accepted, whatever its mode. `fail_ready` returns high in the same cycle that the held abort is consumed. A failure event is accepted on a clock edge where both `fail_valid` and `fail_ready` are high.

The asynchronous status flags are stored as one 2-bit field per exception level. Software can overwrite any field through a plain write port, and this is how the flags are cleared.

Top module: `tcf_dispatch`

## Requirements
- R1: After reset, `async_status` is all zero and both `abort_valid` and `reserved_pulse` are low.
- R2: For an access from level 0, the fault mode is `sys_ctrl[39:38]`. For levels 1 to 3 it is `sys_ctrl[41:40]`. No other bit of `sys_ctrl` affects the result.
- R3: Mode 2'b00 accepts the failure and has no visible effect: no abort, no reserved pulse, no status change.
- R4: Mode 2'b01 raises `abort_valid` in the cycle after acceptance. `abort_addr` equals the faulting address and `abort_fsc` equals 6'h11.
- R5: Mode 2'b10 sets one bit of the status field for `fail_el`, visible in the cycle after acceptance. Level n occupies `async_status[2n+1:2n]`. The bit index is `fail_addr[55]` when `two_ranges` is 1, and 0 when it is 0.
- R6: Mode 2'b11 drives `reserved_pulse` high for exactly one cycle after acceptance. It produces no abort and no status change.
- R7: Status bits are sticky and change only through the software port. A write replaces the addressed field. A flag set in the same cycle is ORed into the written value.
- R8: While `abort_valid` is high and `abort_ready` is low, the abort address and code hold steady and `fail_ready` is low.
- R9: With `fail_valid` low, nothing is accepted and no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fail_valid | input | 1 | Tag check failure event offered |
| fail_ready | output | 1 | Block can accept a failure event |
| fail_addr | input | 64 | Faulting virtual address |
| fail_el | input | 2 | Exception level of the access |
| two_ranges | input | 1 | Translation regime has two address ranges |
| sys_ctrl | input | 64 | System control word holding the mode fields |
| abort_valid | output | 1 | Synchronous abort pending |
| abort_ready | input | 1 | Consumer takes the abort |
| abort_addr | output | 64 | Address reported with the abort |
| abort_fsc | output | 6 | Fault status code of the abort |
| reserved_pulse | output | 1 | One-cycle reserved-mode indication |
| sw_wr_en | input | 1 | Software status write strobe |
| sw_wr_el | input | 2 | Level whose status field is written |
| sw_wr_data | input | 2 | Value written to that field |
| async_status | output | 8 | Sticky status fields, level n at [2n+1:2n] |

## Verification
The bench builds the block with its default parameters. These are a 64-bit address and control word, four exception levels and 2-bit status fields, so the select bit 55 and both mode-field positions are real bit positions that the bench can drive. It uses control words whose off-field bits are deliberately filled, which shows that only the selected field steers the response. It covers every status field and both index choices. It also stalls the abort consumer while a second failure is waiting, and it drives a software write in the same cycle as an asynchronous set.

// File: rtl/tcf_pkg.sv
package tcf_pkg;
  typedef enum logic [1:0] {
    TCF_IGNORE = 2'b00,
    TCF_SYNC   = 2'b01,
    TCF_ASYNC  = 2'b10,
    TCF_RSVD   = 2'b11
  } tcf_mode_e;

  localparam int FSC_W = 6;
  localparam logic [FSC_W-1:0] FSC_TAG_CHECK = 6'h11;
endpackage

// File: rtl/tcf_mode_sel.sv
module tcf_mode_sel
  import tcf_pkg::*;
#(
  parameter int CTRL_W   = 64,
  parameter int EL_W     = 2,
  parameter int USER_LSB = 38,
  parameter int PRIV_LSB = 40
) (
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [EL_W-1:0]   el,
  output tcf_mode_e         mode
);
  logic [1:0] user_fld;
  logic [1:0] priv_fld;

  assign user_fld = ctrl[USER_LSB +: 2];
  assign priv_fld = ctrl[PRIV_LSB +: 2];

  always_comb begin
    if (el == '0) mode = tcf_mode_e'(user_fld);
    else          mode = tcf_mode_e'(priv_fld);
  end
endmodule

// File: rtl/tcf_async_status.sv
module tcf_async_status #(
  parameter int NUM_EL = 4,
  parameter int FLAG_W = 2,
  parameter int EL_W   = 2,
  localparam int IDX_W  = (FLAG_W > 1) ? $clog2(FLAG_W) : 1,
  localparam int FLAT_W = NUM_EL * FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [EL_W-1:0]   set_el,
  input  logic [IDX_W-1:0]  set_idx,
  input  logic              sw_en,
  input  logic [EL_W-1:0]   sw_el,
  input  logic [FLAG_W-1:0] sw_data,
  output logic [FLAT_W-1:0] status
);
  for (genvar e = 0; e < NUM_EL; e++) begin : g_lvl
    logic [FLAG_W-1:0] cur_q;
    logic [FLAG_W-1:0] nxt;
    logic [FLAG_W-1:0] set_mask;

    always_comb begin
      set_mask = '0;
      if (set_en && (set_el == EL_W'(e))) set_mask[set_idx] = 1'b1;
    end

    always_comb begin
      nxt = cur_q;
      if (sw_en && (sw_el == EL_W'(e))) nxt = sw_data;
      nxt = nxt | set_mask;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) cur_q <= '0;
      else        cur_q <= nxt;
    end

    assign status[e*FLAG_W +: FLAG_W] = cur_q;
  end
endmodule

// File: rtl/tcf_abort_stage.sv
module tcf_abort_stage
  import tcf_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  output logic              can_load,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [FSC_W-1:0]  out_fsc
);
  logic              vld_q;
  logic [ADDR_W-1:0] addr_q;

  assign can_load = !vld_q || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)         vld_q <= 1'b0;
    else if (load)      vld_q <= 1'b1;
    else if (out_ready) vld_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    addr_q <= '0;
    else if (load) addr_q <= load_addr;
  end

  assign out_valid = vld_q;
  assign out_addr  = addr_q;
  assign out_fsc   = FSC_TAG_CHECK;
endmodule

// File: rtl/tcf_dispatch.sv
module tcf_dispatch
  import tcf_pkg::*;
#(
  parameter int ADDR_W   = 64,
  parameter int CTRL_W   = 64,
  parameter int NUM_EL   = 4,
  parameter int FLAG_W   = 2,
  parameter int SEL_BIT  = 55,
  parameter int USER_LSB = 38,
  parameter int PRIV_LSB = 40,
  localparam int EL_W   = (NUM_EL > 1) ? $clog2(NUM_EL) : 1,
  localparam int IDX_W  = (FLAG_W > 1) ? $clog2(FLAG_W) : 1,
  localparam int FLAT_W = NUM_EL * FLAG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fail_valid,
  output logic              fail_ready,
  input  logic [ADDR_W-1:0] fail_addr,
  input  logic [EL_W-1:0]   fail_el,
  input  logic              two_ranges,
  input  logic [CTRL_W-1:0] sys_ctrl,
  output logic              abort_valid,
  input  logic              abort_ready,
  output logic [ADDR_W-1:0] abort_addr,
  output logic [FSC_W-1:0]  abort_fsc,
  output logic              reserved_pulse,
  input  logic              sw_wr_en,
  input  logic [EL_W-1:0]   sw_wr_el,
  input  logic [FLAG_W-1:0] sw_wr_data,
  output logic [FLAT_W-1:0] async_status
);
  tcf_mode_e       mode;
  logic            accept;
  logic            can_load;
  logic [IDX_W-1:0] flag_idx;
  logic            rsvd_q;

  tcf_mode_sel #(
    .CTRL_W(CTRL_W), .EL_W(EL_W), .USER_LSB(USER_LSB), .PRIV_LSB(PRIV_LSB)
  ) u_sel (
    .ctrl(sys_ctrl), .el(fail_el), .mode(mode)
  );

  assign fail_ready = can_load;
  assign accept     = fail_valid && fail_ready;
  assign flag_idx   = two_ranges ? IDX_W'(fail_addr[SEL_BIT]) : '0;

  tcf_abort_stage #(.ADDR_W(ADDR_W)) u_abort (
    .clk(clk), .rst_n(rst_n),
    .load(accept && (mode == TCF_SYNC)), .load_addr(fail_addr),
    .can_load(can_load),
    .out_valid(abort_valid), .out_ready(abort_ready),
    .out_addr(abort_addr), .out_fsc(abort_fsc)
  );

  tcf_async_status #(.NUM_EL(NUM_EL), .FLAG_W(FLAG_W), .EL_W(EL_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .set_en(accept && (mode == TCF_ASYNC)), .set_el(fail_el), .set_idx(flag_idx),
    .sw_en(sw_wr_en), .sw_el(sw_wr_el), .sw_data(sw_wr_data),
    .status(async_status)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) rsvd_q <= 1'b0;
    else        rsvd_q <= accept && (mode == TCF_RSVD);
  end

  assign reserved_pulse = rsvd_q;
endmodule

// File: rtl/tcf_dispatch_chk.sv
module tcf_dispatch_chk #(
  parameter int ADDR_W = 64,
  parameter int FSC_W  = 6,
  parameter int FLAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fail_valid,
  input logic              fail_ready,
  input logic              abort_valid,
  input logic              abort_ready,
  input logic [ADDR_W-1:0] abort_addr,
  input logic [FSC_W-1:0]  abort_fsc,
  input logic              reserved_pulse,
  input logic              sw_wr_en,
  input logic [FLAT_W-1:0] async_status
);
  // R4
  abort_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_valid |-> (abort_fsc == 6'h11));

  // R8
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_valid && !abort_ready) |=> (abort_valid && $stable(abort_addr)));

  // R8
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_valid && !abort_ready) |-> !fail_ready);

  // R4
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abort_valid) |-> $past(fail_valid && fail_ready));

  // R6
  rsvd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reserved_pulse |-> $past(fail_valid && fail_ready));

  // R7
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sw_wr_en) |-> (($past(async_status) & ~async_status) == '0));
endmodule

bind tcf_dispatch tcf_dispatch_chk #(
  .ADDR_W(ADDR_W), .FSC_W(tcf_pkg::FSC_W), .FLAT_W(FLAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fail_valid(fail_valid), .fail_ready(fail_ready),
  .abort_valid(abort_valid), .abort_ready(abort_ready), .abort_addr(abort_addr),
  .abort_fsc(abort_fsc), .reserved_pulse(reserved_pulse), .sw_wr_en(sw_wr_en),
  .async_status(async_status)
);

// File: tb/tb_tcf_dispatch.sv
module tb_tcf_dispatch;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fail_valid = 1'b0;
  logic        fail_ready;
  logic [63:0] fail_addr = '0;
  logic [1:0]  fail_el = '0;
  logic        two_ranges = 1'b0;
  logic [63:0] sys_ctrl = '0;
  logic        abort_valid;
  logic        abort_ready = 1'b1;
  logic [63:0] abort_addr;
  logic [5:0]  abort_fsc;
  logic        reserved_pulse;
  logic        sw_wr_en = 1'b0;
  logic [1:0]  sw_wr_el = '0;
  logic [1:0]  sw_wr_data = '0;
  logic [7:0]  async_status;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [7:0]  exp_status = '0;
  logic [63:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tcf_dispatch dut (
    .clk(clk), .rst_n(rst_n), .fail_valid(fail_valid), .fail_ready(fail_ready),
    .fail_addr(fail_addr), .fail_el(fail_el), .two_ranges(two_ranges),
    .sys_ctrl(sys_ctrl), .abort_valid(abort_valid), .abort_ready(abort_ready),
    .abort_addr(abort_addr), .abort_fsc(abort_fsc), .reserved_pulse(reserved_pulse),
    .sw_wr_en(sw_wr_en), .sw_wr_el(sw_wr_el), .sw_wr_data(sw_wr_data),
    .async_status(async_status)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mk_ctrl(input logic [1:0] um, input logic [1:0] pm);
    logic [63:0] w;
    w = 64'hA5C3_F0F0_0F0F_3C5A;
    w[39:38] = um;
    w[41:40] = pm;
    return w;
  endfunction

  // Scoreboard monitor: pops expected aborts as the consumer takes them
  always begin
    @(negedge clk);
    #2;
    if (rst_n && abort_valid && abort_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4", "unexpected abort", abort_addr, 64'h0);
      end else begin
        logic [63:0] e;
        e = exp_q.pop_front();
        check(abort_addr == e, "R4", "abort address", abort_addr, e);
        check(abort_fsc == 6'h11, "R4", "abort code", 64'(abort_fsc), 64'h11);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual %0d expected <= 20000 cycles", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // Drive one failure, compute the expected response, check the cycle after acceptance
  task automatic send(input string req, input logic [63:0] addr, input logic [1:0] el,
                      input bit tr, input logic [63:0] ctrl);
    logic [1:0] mode;
    logic [7:0] prev;
    mode = (el == 2'd0) ? ctrl[39:38] : ctrl[41:40];
    prev = async_status;
    @(negedge clk);
    fail_valid = 1'b1; fail_addr = addr; fail_el = el; two_ranges = tr; sys_ctrl = ctrl;
    while (!fail_ready) @(negedge clk);
    if (mode == 2'b01) exp_q.push_back(addr);
    if (mode == 2'b10) exp_status[2*el + ((tr && addr[55]) ? 1 : 0)] = 1'b1;
    @(negedge clk);
    fail_valid = 1'b0;
    check(reserved_pulse == (mode == 2'b11), req, "reserved pulse", 64'(reserved_pulse),
          64'(mode == 2'b11));
    check(async_status == exp_status, req, "status", 64'(async_status), 64'(exp_status));
    if (abort_ready)
      check(abort_valid == (mode == 2'b01), req, "abort valid", 64'(abort_valid),
            64'(mode == 2'b01));
    if (mode == 2'b00)
      check(async_status == prev, req, "ignored mode left status", 64'(async_status), 64'(prev));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(async_status == 8'h00, "R1", "status after reset", 64'(async_status), 64'h0);
    check(!abort_valid, "R1", "abort after reset", 64'(abort_valid), 64'h0);
    check(!reserved_pulse, "R1", "reserved after reset", 64'(reserved_pulse), 64'h0);
    rst_n = 1'b1;

    // R9 idle: nothing changes without fail_valid
    sys_ctrl = mk_ctrl(2'b11, 2'b11);
    repeat (3) @(negedge clk);
    check(!abort_valid && !reserved_pulse && async_status == 8'h0, "R9", "idle outputs",
          {abort_valid, reserved_pulse, async_status}, 64'h0);

    // R3 ignore mode at user and privileged level
    send("R3", 64'h0080_0000_0000_1000, 2'd0, 1'b1, mk_ctrl(2'b00, 2'b10));
    send("R3", 64'h0000_0000_0000_2000, 2'd2, 1'b0, mk_ctrl(2'b10, 2'b00));

    // R4 synchronous abort, R2 field choice
    send("R4", 64'h1234_5678_9ABC_DEF0, 2'd1, 1'b0, mk_ctrl(2'b00, 2'b01));
    send("R2", 64'hFFFF_0000_0000_0040, 2'd0, 1'b0, mk_ctrl(2'b01, 2'b11));

    // R5 asynchronous flag: index from bit 55 only with two ranges
    send("R5", 64'h0080_0000_0000_0000, 2'd1, 1'b1, mk_ctrl(2'b00, 2'b10));
    send("R5", 64'h0080_0000_0000_0000, 2'd2, 1'b0, mk_ctrl(2'b00, 2'b10));
    send("R5", 64'h0000_0000_0000_0100, 2'd3, 1'b1, mk_ctrl(2'b00, 2'b10));
    send("R2", 64'h0080_0000_0000_0200, 2'd0, 1'b1, mk_ctrl(2'b10, 2'b01));

    // R6 reserved mode pulses one cycle only
    send("R6", 64'h0000_0000_0000_0300, 2'd3, 1'b1, mk_ctrl(2'b00, 2'b11));
    @(negedge clk);
    check(!reserved_pulse, "R6", "pulse width", 64'(reserved_pulse), 64'h0);

    // R7 sticky bits stay set over idle cycles
    repeat (4) @(negedge clk);
    check(async_status == exp_status, "R7", "sticky hold", 64'(async_status), 64'(exp_status));

    // R7 software write replaces a field
    sw_wr_en = 1'b1; sw_wr_el = 2'd1; sw_wr_data = 2'b00;
    @(negedge clk);
    sw_wr_en = 1'b0;
    exp_status[3:2] = 2'b00;
    check(async_status == exp_status, "R7", "software clear", 64'(async_status), 64'(exp_status));

    // R7 write and set in the same cycle: set ORed in
    fail_valid = 1'b1; fail_addr = 64'h0080_0000_0000_0000; fail_el = 2'd2;
    two_ranges = 1'b1; sys_ctrl = mk_ctrl(2'b00, 2'b10);
    sw_wr_en = 1'b1; sw_wr_el = 2'd2; sw_wr_data = 2'b00;
    @(negedge clk);
    fail_valid = 1'b0; sw_wr_en = 1'b0;
    exp_status[5:4] = 2'b10;
    check(async_status == exp_status, "R7", "write with set", 64'(async_status), 64'(exp_status));

    // R8 back-pressure
    abort_ready = 1'b0;
    send("R8", 64'hAAAA_0000_0000_0010, 2'd1, 1'b0, mk_ctrl(2'b00, 2'b01));
    fail_valid = 1'b1; fail_addr = 64'hBBBB_0000_0000_0020; fail_el = 2'd3;
    sys_ctrl = mk_ctrl(2'b00, 2'b01);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(!fail_ready, "R8", "ready while stalled", 64'(fail_ready), 64'h0);
      check(abort_valid && abort_addr == 64'hAAAA_0000_0000_0010, "R8", "held abort",
            abort_addr, 64'hAAAA_0000_0000_0010);
    end
    exp_q.push_back(64'hBBBB_0000_0000_0020);
    abort_ready = 1'b1;
    @(negedge clk);
    fail_valid = 1'b0;
    check(abort_valid && abort_addr == 64'hBBBB_0000_0000_0020, "R8", "second abort loaded",
          abort_addr, 64'hBBBB_0000_0000_0020);
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R4", "all aborts delivered", 64'(exp_q.size()), 64'h0);
    check(!abort_valid, "R8", "abort drained", 64'(abort_valid), 64'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule